// File: doc/BRIEF.md
# Port Packet Admission and Failure Policy Gate

This block decides, one packet at a time, whether a serial link port may accept an inbound packet and whether it may send an outbound one. Software sets a receive enable, a transmit enable and a lockout bit. Maintenance packets get through even when the matching enable is off. Lockout overrides both enables and shuts packet traffic down in both directions. Control symbols, link requests and training do not pass through this gate, so none of these settings can block them.

On the transmit side, a two-bit policy sets what the port does once the link error-rate count reaches the failed threshold. The four choices are:
- carry on as before;
- discard packets that are being resent after a packet-not-accepted reply, until the count drops back under the threshold;
- stall the upstream queue;
- discard every outbound packet.

The last two choices last until software clears a sticky failure-encountered state. A separate sticky flag records that a packet was discarded. Software clears that flag with a write-one-to-clear pulse.

Top module: `port_pkt_gate`

## Requirements
- R1: When `rx_valid_i` is 1, exactly one of `rx_accept_o` and `rx_reject_o` is 1 in the same cycle. Accept is chosen when lockout is 0 and either `rx_en_i` or `rx_maint_i` is 1. When `rx_valid_i` is 0, both outputs are 0.
- R2: When `tx_en_i` is 0, a non-maintenance packet (`tx_maint_i`=0) gets neither `tx_allow_o` nor `tx_drop_o`. A maintenance packet is still eligible.
- R3: When `lockout_i` is 1, every received packet is rejected, and no packet is allowed or dropped on transmit, whatever the enables and maintenance flags say.
- R4: `fail_enc_o` rises in the cycle after the first cycle in which `err_cnt_i >= fail_thresh_i`. It then holds regardless of the counter until `fail_clr_i` is pulsed. It reads 0 in the cycle after the pulse, because clear beats set in the same cycle.
- R5: With policy 2'b00, `tx_drop_o` and `tx_stall_o` stay 0, and an eligible valid packet is always allowed.
- R6: With policy 2'b01, an eligible packet flagged as a resend (`tx_retry_i`=1) is dropped in any cycle where `err_cnt_i >= fail_thresh_i`, instead of being allowed. In cycles where the count is below the threshold, and for packets that are not resends, it is allowed.
- R7: With policy 2'b10, `tx_stall_o` equals `fail_enc_o`. While stalled, no packet is allowed and none is dropped.
- R8: With policy 2'b11, every eligible valid packet is dropped while `fail_enc_o` is 1, and is allowed otherwise.
- R9: `pkt_dropped_o` becomes 1 in the cycle after any cycle with `tx_drop_o`=1. It holds until `drop_clr_i` is pulsed and reads 0 in the following cycle. A drop in the same cycle as the clear keeps it at 1.
- R10: While `rst_ni` is 0, `fail_enc_o` and `pkt_dropped_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Inbound packet enable |
| tx_en_i | input | 1 | Outbound packet enable |
| lockout_i | input | 1 | Stops all packet traffic; overrides both enables |
| policy_i | input | 2 | Behaviour once the failed threshold is reached (00 continue, 01 drop resends, 10 stall, 11 drop all) |
| err_cnt_i | input | CNT_W | Current error-rate count |
| fail_thresh_i | input | CNT_W | Failed threshold |
| fail_clr_i | input | 1 | Pulse that clears the failure-encountered state |
| drop_clr_i | input | 1 | Write-one-to-clear pulse for the dropped flag |
| rx_valid_i | input | 1 | Inbound packet present |
| rx_maint_i | input | 1 | Inbound packet is a maintenance request |
| tx_valid_i | input | 1 | Outbound packet present |
| tx_maint_i | input | 1 | Outbound packet is a maintenance packet |
| tx_retry_i | input | 1 | Outbound packet is a resend after packet-not-accepted |
| rx_accept_o | output | 1 | Accept the inbound packet |
| rx_reject_o | output | 1 | Answer the inbound packet with packet-not-accepted |
| tx_allow_o | output | 1 | Outbound packet may be sent |
| tx_drop_o | output | 1 | Discard the outbound packet |
| tx_stall_o | output | 1 | Backpressure to the outbound queue |
| fail_enc_o | output | 1 | Failure-encountered state |
| pkt_dropped_o | output | 1 | Sticky packet-dropped flag |

## Verification
The bench targets the boundary where the error count equals the threshold. A design that compares with a strict greater-than would keep policy 01 sending resends and would never set the failure state at that count. It also covers a clear pulse that lands while the count is still over the threshold. Letting set win there would leave the state stuck, while clear-first shows one cycle of 0 before it sets again. It checks a drop and a dropped-flag clear in the same cycle, where a clear-first flag would lose the event. Finally, it runs lockout together with maintenance traffic, where an enable-first decode would let maintenance packets through a locked port.

// File: rtl/port_pkt_gate_pkg.sv
package port_pkt_gate_pkg;
  typedef enum logic [1:0] {
    POL_CONTINUE  = 2'b00,
    POL_DROP_NACK = 2'b01,
    POL_STALL     = 2'b10,
    POL_DROP_ALL  = 2'b11
  } fail_policy_e;
endpackage

// File: rtl/pkt_fail_tracker.sv
module pkt_fail_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic [CNT_W-1:0] fail_thresh_i,
  input  logic             fail_clr_i,
  output logic             over_o,
  output logic             fail_enc_o
);
  logic fail_q;

  assign over_o = (err_cnt_i >= fail_thresh_i);

  // clear wins; a still-high count re-sets on the following cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fail_q <= 1'b0;
    else if (fail_clr_i) fail_q <= 1'b0;
    else if (over_o)     fail_q <= 1'b1;
  end

  assign fail_enc_o = fail_q;
endmodule

// File: rtl/pkt_rx_admit.sv
module pkt_rx_admit (
  input  logic rx_en_i,
  input  logic lockout_i,
  input  logic rx_valid_i,
  input  logic rx_maint_i,
  output logic rx_accept_o,
  output logic rx_reject_o
);
  logic ok;

  assign ok          = !lockout_i && (rx_en_i || rx_maint_i);
  assign rx_accept_o = rx_valid_i && ok;
  assign rx_reject_o = rx_valid_i && !ok;
endmodule

// File: rtl/pkt_tx_policy.sv
module pkt_tx_policy
  import port_pkt_gate_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_en_i,
  input  logic         lockout_i,
  input  fail_policy_e policy_i,
  input  logic         over_i,
  input  logic         fail_enc_i,
  input  logic         drop_clr_i,
  input  logic         tx_valid_i,
  input  logic         tx_maint_i,
  input  logic         tx_retry_i,
  output logic         tx_allow_o,
  output logic         tx_drop_o,
  output logic         tx_stall_o,
  output logic         pkt_dropped_o
);
  logic eligible, discard, dropped_q;

  assign eligible = !lockout_i && (tx_en_i || tx_maint_i);

  always_comb begin
    tx_stall_o = 1'b0;
    discard    = 1'b0;
    unique case (policy_i)
      POL_CONTINUE:  ;
      POL_DROP_NACK: discard = over_i && tx_retry_i;
      POL_STALL:     tx_stall_o = fail_enc_i;
      POL_DROP_ALL:  discard = fail_enc_i;
      default:       ;
    endcase
  end

  assign tx_drop_o  = tx_valid_i && eligible && discard;
  assign tx_allow_o = tx_valid_i && eligible && !discard && !tx_stall_o;

  // set beats write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dropped_q <= 1'b0;
    else if (tx_drop_o) dropped_q <= 1'b1;
    else if (drop_clr_i) dropped_q <= 1'b0;
  end

  assign pkt_dropped_o = dropped_q;
endmodule

// File: rtl/port_pkt_gate.sv
module port_pkt_gate
  import port_pkt_gate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic             lockout_i,
  input  logic [1:0]       policy_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic [CNT_W-1:0] fail_thresh_i,
  input  logic             fail_clr_i,
  input  logic             drop_clr_i,
  input  logic             rx_valid_i,
  input  logic             rx_maint_i,
  input  logic             tx_valid_i,
  input  logic             tx_maint_i,
  input  logic             tx_retry_i,
  output logic             rx_accept_o,
  output logic             rx_reject_o,
  output logic             tx_allow_o,
  output logic             tx_drop_o,
  output logic             tx_stall_o,
  output logic             fail_enc_o,
  output logic             pkt_dropped_o
);
  logic over;

  pkt_fail_tracker #(.CNT_W(CNT_W)) u_fail (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .err_cnt_i     (err_cnt_i),
    .fail_thresh_i (fail_thresh_i),
    .fail_clr_i    (fail_clr_i),
    .over_o        (over),
    .fail_enc_o    (fail_enc_o)
  );

  pkt_rx_admit u_rx (
    .rx_en_i     (rx_en_i),
    .lockout_i   (lockout_i),
    .rx_valid_i  (rx_valid_i),
    .rx_maint_i  (rx_maint_i),
    .rx_accept_o (rx_accept_o),
    .rx_reject_o (rx_reject_o)
  );

  pkt_tx_policy u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_en_i       (tx_en_i),
    .lockout_i     (lockout_i),
    .policy_i      (fail_policy_e'(policy_i)),
    .over_i        (over),
    .fail_enc_i    (fail_enc_o),
    .drop_clr_i    (drop_clr_i),
    .tx_valid_i    (tx_valid_i),
    .tx_maint_i    (tx_maint_i),
    .tx_retry_i    (tx_retry_i),
    .tx_allow_o    (tx_allow_o),
    .tx_drop_o     (tx_drop_o),
    .tx_stall_o    (tx_stall_o),
    .pkt_dropped_o (pkt_dropped_o)
  );
endmodule

// File: rtl/port_pkt_gate_chk.sv
module port_pkt_gate_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lockout_i,
  input logic [1:0]       policy_i,
  input logic [CNT_W-1:0] err_cnt_i,
  input logic [CNT_W-1:0] fail_thresh_i,
  input logic             fail_clr_i,
  input logic             rx_valid_i,
  input logic             rx_accept_o,
  input logic             rx_reject_o,
  input logic             tx_allow_o,
  input logic             tx_drop_o,
  input logic             tx_stall_o,
  input logic             fail_enc_o,
  input logic             pkt_dropped_o
);
  AST_RX_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> $countones({rx_accept_o, rx_reject_o}) == 1); // R1
  AST_LOCK_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockout_i && rx_valid_i) |-> rx_reject_o); // R3
  AST_LOCK_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |-> (!tx_allow_o && !tx_drop_o)); // R3
  AST_FAIL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_i >= fail_thresh_i && !fail_clr_i) |=> fail_enc_o); // R4
  AST_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_enc_o && !fail_clr_i) |=> fail_enc_o); // R4
  AST_CONT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'b00) |-> (!tx_drop_o && !tx_stall_o)); // R5
  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stall_o |-> (!tx_allow_o && !tx_drop_o)); // R7
  AST_DROP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_drop_o |=> pkt_dropped_o); // R9
endmodule

bind port_pkt_gate port_pkt_gate_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/port_pkt_gate_bench.sv
module port_pkt_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_en, tx_en, lockout, fail_clr, drop_clr;
  logic rx_valid, rx_maint, tx_valid, tx_maint, tx_retry;
  logic [1:0] policy;
  logic [CNT_W-1:0] err_cnt, thresh;
  logic rx_accept, rx_reject, tx_allow, tx_drop, tx_stall, fail_enc, pkt_dropped;

  int vectors = 0, errors = 0;
  bit m_fail = 0, m_drp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_pkt_gate #(.CNT_W(CNT_W)) u_port_pkt_gate (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .lockout_i(lockout), .policy_i(policy), .err_cnt_i(err_cnt),
    .fail_thresh_i(thresh), .fail_clr_i(fail_clr), .drop_clr_i(drop_clr),
    .rx_valid_i(rx_valid), .rx_maint_i(rx_maint), .tx_valid_i(tx_valid),
    .tx_maint_i(tx_maint), .tx_retry_i(tx_retry), .rx_accept_o(rx_accept),
    .rx_reject_o(rx_reject), .tx_allow_o(tx_allow), .tx_drop_o(tx_drop),
    .tx_stall_o(tx_stall), .fail_enc_o(fail_enc), .pkt_dropped_o(pkt_dropped)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare outputs against the behavioural model, then advance the model at the edge
  task automatic step();
    bit over, elig, e_stall, e_drop, e_allow, e_acc;
    string ptag;
    #1;
    over    = (err_cnt >= thresh);
    elig    = !lockout && (tx_en || tx_maint);
    e_stall = (policy == 2'd2) && m_fail;
    e_drop  = tx_valid && elig && (((policy == 2'd3) && m_fail) ||
                                   ((policy == 2'd1) && over && tx_retry));
    e_allow = tx_valid && elig && !e_drop && !e_stall;
    e_acc   = rx_valid && !lockout && (rx_en || rx_maint);
    case (policy)
      2'd0: ptag = "R5";
      2'd1: ptag = "R6";
      2'd2: ptag = "R7";
      default: ptag = "R8";
    endcase
    check(lockout ? "R3" : "R1", "rx_accept", rx_accept, e_acc);
    check(lockout ? "R3" : "R1", "rx_reject", rx_reject, rx_valid && !e_acc);
    check(lockout ? "R3" : (!tx_en ? "R2" : ptag), "tx_allow", tx_allow, e_allow);
    check(lockout ? "R3" : ptag, "tx_drop", tx_drop, e_drop);
    check(ptag, "tx_stall", tx_stall, e_stall);
    check("R4", "fail_enc", fail_enc, m_fail);
    check("R9", "pkt_dropped", pkt_dropped, m_drp);
    @(posedge clk);
    m_fail = fail_clr ? 1'b0 : (m_fail || over);
    m_drp  = e_drop || (m_drp && !drop_clr);
    @(negedge clk);
  endtask

  task automatic rand_inputs(int lock_w);
    rx_en    = ($urandom % 4) != 0;
    tx_en    = ($urandom % 4) != 0;
    lockout  = ($urandom % lock_w) == 0;
    rx_valid = ($urandom % 3) != 0;
    rx_maint = ($urandom % 3) == 0;
    tx_valid = ($urandom % 3) != 0;
    tx_maint = ($urandom % 3) == 0;
    tx_retry = ($urandom % 2) == 0;
    fail_clr = ($urandom % 12) == 0;
    drop_clr = ($urandom % 8) == 0;
    err_cnt  = CNT_W'(16 + ($urandom % 8));
  endtask

  initial begin
    rx_en = 0; tx_en = 0; lockout = 0; fail_clr = 0; drop_clr = 0;
    rx_valid = 0; rx_maint = 0; tx_valid = 0; tx_maint = 0; tx_retry = 0;
    policy = 2'd3; err_cnt = 8'd50; thresh = 8'd20;
    // R10: state held at zero in reset even with count over threshold
    repeat (3) @(negedge clk);
    check("R10", "fail_enc in reset", fail_enc, 1'b0);
    check("R10", "pkt_dropped in reset", pkt_dropped, 1'b0);
    err_cnt = 8'd0;
    rst_ni = 1'b1;
    @(negedge clk);

    // R4 boundary: count equal to threshold sets the state
    err_cnt = 8'd20; step();
    err_cnt = 8'd0;  step();
    check("R4", "held after count falls", fail_enc, 1'b1);
    // R4: clear while over -> 0 for one cycle, then set again
    err_cnt = 8'd20; fail_clr = 1; step();
    check("R4", "clear beats set", fail_enc, 1'b0);
    fail_clr = 0; step();
    check("R4", "re-set after clear", fail_enc, 1'b1);
    // R9: drop (policy 11) concurrent with clear keeps flag set
    tx_en = 1; tx_valid = 1; drop_clr = 1; step();
    check("R9", "drop beats clear", pkt_dropped, 1'b1);
    tx_valid = 0; step();
    check("R9", "clear takes effect", pkt_dropped, 1'b0);
    drop_clr = 0;
    // R3: lockout blocks maintenance traffic too
    lockout = 1; rx_valid = 1; rx_maint = 1; rx_en = 1; tx_valid = 1; tx_maint = 1; step();
    lockout = 0; rx_valid = 0; tx_valid = 0; fail_clr = 1; step();
    fail_clr = 0; err_cnt = 8'd0; step();

    for (int p = 0; p < 4; p++) begin
      policy = 2'(p);
      for (int i = 0; i < 600; i++) begin
        rand_inputs(8);
        step();
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule